// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block decides when an on-chip debug session reaches its trigger point. It has three comparator match channels and a software trigger. Software writes a control word to arm it, and the sequencer enters its first intermediate state. After that, each match pulse on an enabled channel moves the sequencer to the next state configured for that channel in the current state's control word. A session ends when the sequencer reaches the final state. It spends exactly one cycle there and then drops back to disarmed. The current state is visible as a 3-bit flag field. A separate breakpoint output fires in the same cycle as any match on a channel that has breakpoints enabled.

The named states are:

- IDLE: disarmed.
- ONE, TWO and THREE: intermediate states.
- FINAL: the end-of-session state.

The named transitions are:

- Arm: IDLE to ONE.
- Step: a move among ONE, TWO and THREE in any direction, chosen per channel.
- Finish: to FINAL, by a channel whose target is FINAL or by the software trigger.
- Complete: FINAL to IDLE.
- Abort: any armed state to IDLE when software clears the arm bit.

Software writes through a simple write port:

- Select 0 is the control word: bit 0 arm, bit 1 trigger, bits 2..4 breakpoint enables for channels 0..2. Every control write sets all of these fields.
- Selects 1, 2 and 3 hold the control words for states ONE, TWO and THREE.

Top module: `dbgseq_top`

## Requirements
- R1: After reset, state_flags is 000, and arm_status, session_done and brk_hit are all 0.
- R2: State flags use these codes: IDLE 000, ONE 001, TWO 010, THREE 011, FINAL 100. A control write with bit 0 set while in IDLE shows 001 and arm_status 1 one cycle after the write.
- R3: While disarmed, match pulses and trigger writes leave the state at IDLE and brk_hit at 0.
- R4: In a state control word, channel c uses three bits. Bit 3c is the enable. Bits 3c+2:3c+1 are the target: 00 ONE, 01 TWO, 10 THREE, 11 FINAL. A match on an enabled channel moves the state to its target one cycle later, in any direction among ONE to THREE.
- R5: A match on a channel that is not enabled in the current state causes no transition.
- R6: When several enabled channels match in the same cycle, a channel whose target is FINAL wins. Otherwise the lowest-numbered channel wins, and the other matches are dropped.
- R7: A control write with bit 1 and bit 0 set while armed moves the state to FINAL one cycle later, whatever the matches do in that cycle.
- R8: FINAL lasts exactly one cycle. session_done is high exactly in that cycle. The next state is IDLE, with arm_status cleared.
- R9: A control write with bit 0 clear while armed returns the state to IDLE one cycle later. This takes priority over the trigger and the matches, and session_done stays low.
- R10: While armed, brk_hit is high in the same cycle as a match on any channel whose breakpoint enable is set. That match still drives sequencer transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1..3 state control words |
| wr_data | input | 3*NCH | Write data |
| match | input | NCH | Single-cycle comparator match pulses |
| state_flags | output | 3 | Current state code |
| arm_status | output | 1 | Arm bit readback; self-clears when a session completes |
| session_done | output | 1 | High during the single FINAL cycle |
| brk_hit | output | 1 | Immediate breakpoint, combinational from match |

## Verification
brk_hit is combinational, so the bench checks it in the same cycle as the match, shortly after driving the input. Writes and match pulses are registered into the state at the next rising edge. The bench drives stimulus on a falling edge and reads state_flags, arm_status and session_done at the following falling edge, one cycle later. The FINAL cycle is then checked at that falling edge, and the return to IDLE is checked one further falling edge later.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_FINAL = 3'd4
    } seq_state_t;

    localparam logic [1:0] TGT_FINAL = 2'b11;

    function automatic seq_state_t tgt_to_state(input logic [1:0] tgt);
        return seq_state_t'({1'b0, tgt} + 3'd1);
    endfunction
endpackage

// File: rtl/dbgseq_regs.sv
module dbgseq_regs
    import dbgseq_pkg::*;
#(
    parameter int NCH = 3,
    localparam int DW = 3 * NCH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  seq_state_t      state,
    output logic            arm_set,
    output logic            arm_clr,
    output logic            trig,
    output logic            arm_q,
    output logic [NCH-1:0]  brk_en,
    output logic [DW-1:0]   cur_cfg
);
    logic [DW-1:0] cfg_q [3];
    logic          ctl_wr;

    assign ctl_wr  = wr_en && (wr_sel == 2'd0);
    assign arm_set = ctl_wr && wr_data[0];
    assign arm_clr = ctl_wr && !wr_data[0];
    assign trig    = ctl_wr && wr_data[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_en <= '0;
            arm_q  <= 1'b0;
        end else begin
            if (ctl_wr)
                brk_en <= wr_data[2 +: NCH];
            if (arm_clr || state == ST_FINAL)
                arm_q <= 1'b0;
            else if (arm_set && state == ST_IDLE)
                arm_q <= 1'b1;
        end
    end

    for (genvar s = 0; s < 3; s++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[s] <= '0;
            else if (wr_en && wr_sel == 2'(s + 1))
                cfg_q[s] <= wr_data;
        end
    end

    always_comb begin
        unique case (state)
            ST_ONE:   cur_cfg = cfg_q[0];
            ST_TWO:   cur_cfg = cfg_q[1];
            ST_THREE: cur_cfg = cfg_q[2];
            default:  cur_cfg = '0;
        endcase
    end

    a_r8_arm_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINAL) |=> !arm_q);
    a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_set && state == ST_IDLE) |=> arm_q);
endmodule

// File: rtl/dbgseq_arbiter.sv
module dbgseq_arbiter
    import dbgseq_pkg::*;
#(
    parameter int NCH = 3,
    localparam int DW = 3 * NCH
) (
    input  logic [NCH-1:0] match,
    input  logic [DW-1:0]  cfg,
    output logic           hit,
    output seq_state_t     target
);
    logic [NCH-1:0] valid;
    logic [NCH-1:0] to_final;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign valid[c]    = match[c] && cfg[3*c];
        assign to_final[c] = valid[c] && (cfg[3*c+1 +: 2] == TGT_FINAL);
    end

    always_comb begin
        hit    = |valid;
        target = ST_IDLE;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (valid[c])
                target = tgt_to_state(cfg[3*c+1 +: 2]);
        end
        if (|to_final)
            target = ST_FINAL;
    end
endmodule

// File: rtl/dbgseq_fsm.sv
module dbgseq_fsm
    import dbgseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_set,
    input  logic       arm_clr,
    input  logic       trig,
    input  logic       hit,
    input  seq_state_t target,
    output seq_state_t state,
    output logic [2:0] state_flags,
    output logic       session_done
);
    seq_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (arm_set)
                    nxt = ST_ONE;
            end
            ST_ONE, ST_TWO, ST_THREE: begin
                if (arm_clr)
                    nxt = ST_IDLE;
                else if (trig)
                    nxt = ST_FINAL;
                else if (hit)
                    nxt = target;
            end
            ST_FINAL: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        state_flags  = state;
        session_done = (state == ST_FINAL);
    end

    a_r8_final_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINAL) |=> (state == ST_IDLE));
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm_set) |=> (state == ST_IDLE));
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_clr && state != ST_IDLE) |=> (state == ST_IDLE));
    a_r7_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !arm_clr && state inside {ST_ONE, ST_TWO, ST_THREE}) |=> (state == ST_FINAL));
    a_r5_no_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !trig && !arm_clr && state inside {ST_ONE, ST_TWO, ST_THREE}) |=> $stable(state));
endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
    import dbgseq_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [3*NCH-1:0]   wr_data,
    input  logic [NCH-1:0]     match,
    output logic [2:0]         state_flags,
    output logic               arm_status,
    output logic               session_done,
    output logic               brk_hit
);
    localparam int DW = 3 * NCH;

    seq_state_t     state;
    seq_state_t     target;
    logic           arm_set, arm_clr, trig, hit;
    logic [NCH-1:0] brk_en;
    logic [DW-1:0]  cur_cfg;

    dbgseq_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .state(state), .arm_set(arm_set),
        .arm_clr(arm_clr), .trig(trig), .arm_q(arm_status),
        .brk_en(brk_en), .cur_cfg(cur_cfg)
    );

    dbgseq_arbiter #(.NCH(NCH)) u_arb (
        .match(match), .cfg(cur_cfg), .hit(hit), .target(target)
    );

    dbgseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
        .trig(trig), .hit(hit), .target(target), .state(state),
        .state_flags(state_flags), .session_done(session_done)
    );

    assign brk_hit = (state != ST_IDLE) && |(match & brk_en);

    a_r10_brk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !brk_hit);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        session_done |=> !session_done);
endmodule

// File: tb/dbgseq_top_test.sv
module dbgseq_top_test;
    localparam int NCH = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [3*NCH-1:0] wr_data = '0;
    logic [NCH-1:0]   match = '0;
    logic [2:0]       state_flags;
    logic             arm_status, session_done, brk_hit;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dbgseq_top #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .match(match), .state_flags(state_flags),
        .arm_status(arm_status), .session_done(session_done), .brk_hit(brk_hit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [8:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        match = m;
        @(negedge clk);
        match = '0;
    endtask

    task automatic t_reset;
        chk("R1 flags", state_flags, 0);
        chk("R1 arm", arm_status, 0);
        chk("R1 done", session_done, 0);
        chk("R1 brk", brk_hit, 0);
    endtask

    task automatic t_config_and_walk;
        wr(2'd1, 9'b111_101_011);
        wr(2'd2, 9'b001_101_000);
        wr(2'd3, 9'b000_011_001);
        pulse(3'b001);
        chk("R3 match idle", state_flags, 0);
        wr(2'd0, 9'd1);
        chk("R2 armed flags", state_flags, 1);
        chk("R2 arm_status", arm_status, 1);
        pulse(3'b001);
        chk("R4 one->two", state_flags, 2);
        pulse(3'b001);
        chk("R5 disabled ch0", state_flags, 2);
        pulse(3'b100);
        chk("R4 two->one", state_flags, 1);
        pulse(3'b010);
        chk("R4 one->three", state_flags, 3);
        pulse(3'b011);
        chk("R6 ch0 over ch1", state_flags, 1);
        pulse(3'b010);
        chk("R4 one->three again", state_flags, 3);
        pulse(3'b110);
        chk("R6 ch2 disabled in three", state_flags, 2);
        pulse(3'b110);
        chk("R6 ch1 over ch2", state_flags, 3);
        pulse(3'b001);
        chk("R4 three->one", state_flags, 1);
        pulse(3'b111);
        chk("R6 final wins", state_flags, 4);
        chk("R8 done high", session_done, 1);
        @(negedge clk);
        chk("R8 back idle", state_flags, 0);
        chk("R8 done low", session_done, 0);
        chk("R8 arm cleared", arm_status, 0);
    endtask

    task automatic t_trigger;
        wr(2'd0, 9'd1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 9'd3; match = 3'b001;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; match = '0;
        chk("R7 trigger to final", state_flags, 4);
        chk("R7 done", session_done, 1);
        @(negedge clk);
        chk("R7 then idle", state_flags, 0);
    endtask

    task automatic t_abort;
        wr(2'd0, 9'd1);
        pulse(3'b001);
        chk("R9 in two", state_flags, 2);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 9'd2; match = 3'b100;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; match = '0;
        chk("R9 abort idle", state_flags, 0);
        chk("R9 no done", session_done, 0);
        chk("R9 arm low", arm_status, 0);
    endtask

    task automatic t_breakpoint;
        wr(2'd0, 9'b0_0000_1001);
        @(negedge clk);
        match = 3'b010;
        #1 chk("R10 brk same cycle", brk_hit, 1);
        @(negedge clk);
        match = '0;
        chk("R10 transition too", state_flags, 3);
        @(negedge clk);
        match = 3'b001;
        #1 chk("R10 other ch no brk", brk_hit, 0);
        @(negedge clk);
        match = '0;
        wr(2'd0, 9'b0_0000_1000);
        chk("R9 disarm keep brk", state_flags, 0);
        @(negedge clk);
        match = 3'b010;
        #1 chk("R3 brk idle", brk_hit, 0);
        @(negedge clk);
        match = '0;
        chk("R3 still idle", state_flags, 0);
        wr(2'd0, 9'b0_0000_1010);
        chk("R3 trig idle", state_flags, 0);
        chk("R3 trig idle done", session_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config_and_walk();
        t_trigger();
        t_abort();
        t_breakpoint();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule